// File: doc/BRIEF.md
# Debug Mode Controller

This block sits beside a CPU core and decides when the core leaves normal execution for debug mode and when it returns. A debugger programs one control word through a simple write/read port. The word holds a master enable, a halt request, a sticky single-step flag, a one-shot fetch-substitution flag, a trace-style level and a two-bit event selector. The core reports its status to the block: sleeping, wake finished, instruction retired, debug-return executed, and breakpoint or watchpoint hit. It also reports when a trace message enters the transmit queue and when an instruction fetch happens.

A four-state machine drives the mode. The states are `ST_RUN` (normal execution), `ST_WAKE` (the core is asleep and a wake has been requested), `ST_DEBUG` (halted in debug mode) and `ST_STEP` (one instruction runs between two debug visits). The transitions are:

- *enter_now*: `ST_RUN` to `ST_DEBUG`.
- *enter_sleeping*: `ST_RUN` to `ST_WAKE`.
- *wake_ok*: `ST_WAKE` to `ST_DEBUG`.
- *resume*: `ST_DEBUG` to `ST_RUN`.
- *step_go*: `ST_DEBUG` to `ST_STEP`.
- *step_done*: `ST_STEP` to `ST_DEBUG`.

Every entry into debug mode produces a one-cycle halt request. When the substitution flag is set, the first fetch after leaving debug mode is steered to the debug instruction register.

Top module: `dbg_mode_ctrl`

Control word layout. Any bit not listed below is reserved.

| Bit | Field | Access |
|-----|-------|--------|
| 0 | step | read/write |
| 1 | halt request | read/write |
| 2 | enable | read/write |
| 3 | trace style | read/write |
| 5:4 | event select | read/write |
| 6 | fetch substitution | read/write |
| 7 | core reset | write-only, reads as zero |

## Requirements
- R1: After reset, every control field reads as zero. `dbg_mode`, `wake_req`, `halt_req`, `evt_out`, `fetch_sel_dir` and `trace_qa` are all low.
- R2: While enable (bit 2) is one, the core enters debug mode on the first clock edge after a stored halt request (bit 1) or a `bkpt_hit` cycle. While enable is zero, the halt request is not stored and breakpoints cause no entry.
- R3: If `core_sleep` is high when an entry is accepted, the block first goes to `ST_WAKE` and holds `wake_req` high. It enters debug mode on the edge where `core_wake_done` is seen. The halt request bit stays one until that entry.
- R4: The halt request bit clears on the clock edge that enters debug mode. A debugger write that sets it on that same edge loses to the clear.
- R5: If step (bit 0) and enable are one when `core_debug_ret` is seen in debug mode, the block leaves debug mode. It re-enters on the edge where exactly one `core_retire` is seen, and stays out until that retire arrives.
- R6: The step bit is never cleared by hardware. It reads as one across steps until the debugger writes zero.
- R7: If fetch substitution (bit 6) is one when debug mode is left, `fetch_sel_dir` goes high on that edge. It stays high until a `core_fetch` cycle, and on that edge both `fetch_sel_dir` and bit 6 clear.
- R8: A write with the core reset bit (bit 7) set leaves fetch substitution at its previous value, whatever the written bit 6 is. Bit 7 always reads as zero.
- R9: The event select (bits 5:4) is encoded as follows: 00 means no event, 01 means debug-mode entry, 10 means `bkpt_hit`, and 11 means `msg_insert`. `evt_out` is a one-cycle pulse, registered on the edge after the selected condition.
- R10: Trace style (bit 3) is stored as written and driven on `trace_qa` as a level.
- R11: Reserved bits (31:8) ignore writes and read as zero.
- R12: `halt_req` is high for exactly the first cycle of each debug-mode visit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| core_sleep | input | 1 | Core is in sleep |
| core_wake_done | input | 1 | Core finished waking |
| core_retire | input | 1 | One instruction retired |
| core_debug_ret | input | 1 | Debug-return instruction executed |
| core_fetch | input | 1 | An instruction fetch took place |
| bkpt_hit | input | 1 | Breakpoint or watchpoint hit |
| msg_insert | input | 1 | Trace message entered the transmit queue |
| dbg_mode | output | 1 | Core is in debug mode |
| wake_req | output | 1 | Request to wake the core |
| halt_req | output | 1 | One-cycle halt request on debug entry |
| fetch_sel_dir | output | 1 | Next fetch comes from the debug instruction register |
| evt_out | output | 1 | Selected event pulse |
| trace_qa | output | 1 | Trace style level |

## Verification
The assertions assume the core follows its own protocol:

- `core_wake_done` arrives only while a wake is requested.
- `core_debug_ret` is raised only in debug mode.
- `core_retire` in `ST_STEP` stands for the single stepped instruction.

The directed stimulus respects this. It drops `core_sleep` together with the wake-done pulse, pulses debug-return only after `dbg_mode` has been seen high, and issues each core strobe as a lone one-cycle pulse. A write and an entry edge are made to coincide only in the scenario built to test that collision.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAKE  = 2'd1,
        ST_DEBUG = 2'd2,
        ST_STEP  = 2'd3
    } dbg_state_e;

    typedef enum logic [1:0] {
        EVT_NONE  = 2'b00,
        EVT_ENTRY = 2'b01,
        EVT_BKPT  = 2'b10,
        EVT_MSG   = 2'b11
    } evt_sel_e;

    localparam int unsigned BIT_STEP   = 0;
    localparam int unsigned BIT_REQ    = 1;
    localparam int unsigned BIT_EN     = 2;
    localparam int unsigned BIT_QA     = 3;
    localparam int unsigned BIT_EVT_LO = 4;
    localparam int unsigned EVT_W      = 2;
    localparam int unsigned BIT_REPL   = 6;
    localparam int unsigned BIT_RST    = 7;
    localparam int unsigned CTRL_BITS  = 8;

    typedef struct packed {
        logic     repl;
        evt_sel_e evt;
        logic     qa;
        logic     en;
        logic     req;
        logic     step;
    } ctrl_t;

endpackage

// File: rtl/dbgc_ctrl_reg.sv
module dbgc_ctrl_reg
    import dbgc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              enter_dbg,
    input  logic              fetch_sel,
    input  logic              core_fetch,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata
);

    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:CTRL_BITS];

    // Later assignments in this process win, so hardware clears override writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr) begin
                ctrl.step <= wdata[BIT_STEP];
                ctrl.en   <= wdata[BIT_EN];
                ctrl.qa   <= wdata[BIT_QA];
                ctrl.evt  <= evt_sel_e'(wdata[BIT_EVT_LO +: EVT_W]);
                ctrl.req  <= wdata[BIT_REQ] & wdata[BIT_EN];
                if (!wdata[BIT_RST]) begin
                    ctrl.repl <= wdata[BIT_REPL];
                end
            end
            if (enter_dbg) begin
                ctrl.req <= 1'b0;
            end
            if (fetch_sel && core_fetch) begin
                ctrl.repl <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata                          = '0;
        rdata[BIT_STEP]                = ctrl.step;
        rdata[BIT_REQ]                 = ctrl.req;
        rdata[BIT_EN]                  = ctrl.en;
        rdata[BIT_QA]                  = ctrl.qa;
        rdata[BIT_EVT_LO +: EVT_W]     = ctrl.evt;
        rdata[BIT_REPL]                = ctrl.repl;
    end

    // R4: the request bit is gone after the entry edge
    p_req_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enter_dbg |=> !ctrl.req);

    // R7: substitution flag drops once the steered fetch happened
    p_repl_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_sel && core_fetch) |=> !ctrl.repl);

    // R2: a disabled word never holds a request
    p_req_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[BIT_EN]) |=> !ctrl.req);

endmodule

// File: rtl/dbgc_mode_fsm.sv
module dbgc_mode_fsm
    import dbgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic step,
    input  logic repl,
    input  logic core_sleep,
    input  logic core_wake_done,
    input  logic core_retire,
    input  logic core_debug_ret,
    input  logic core_fetch,
    input  logic bkpt_hit,
    output logic enter_dbg,
    output logic dbg_mode,
    output logic wake_req,
    output logic halt_req,
    output logic fetch_sel
);

    dbg_state_e state_q, state_d;
    logic       leave_dbg;
    logic       halt_q;
    logic       fetch_sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (en && (req || bkpt_hit)) begin
                    state_d = core_sleep ? ST_WAKE : ST_DEBUG;
                end
            end
            ST_WAKE: begin
                if (core_wake_done) state_d = ST_DEBUG;
            end
            ST_DEBUG: begin
                if (core_debug_ret) state_d = (step && en) ? ST_STEP : ST_RUN;
            end
            ST_STEP: begin
                if (core_retire) state_d = ST_DEBUG;
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign enter_dbg = (state_d == ST_DEBUG) && (state_q != ST_DEBUG);
    assign leave_dbg = (state_q == ST_DEBUG) && core_debug_ret;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q      <= 1'b0;
            fetch_sel_q <= 1'b0;
        end else begin
            halt_q <= enter_dbg;
            if (leave_dbg && repl) begin
                fetch_sel_q <= 1'b1;
            end else if (core_fetch) begin
                fetch_sel_q <= 1'b0;
            end
        end
    end

    always_comb begin
        dbg_mode  = (state_q == ST_DEBUG);
        wake_req  = (state_q == ST_WAKE);
        halt_req  = halt_q;
        fetch_sel = fetch_sel_q;
    end

    // R2: with enable low, normal run is never left
    p_no_entry_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !en) |=> state_q == ST_RUN);

    // R3: wake request held until the core reports it is awake
    p_wake_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !core_wake_done) |=> state_q == ST_WAKE);

    // R5: one retirement while stepping brings the core back
    p_step_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && core_retire) |=> state_q == ST_DEBUG);

    // R12: each debug visit opens with a halt request
    p_halt_on_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_mode) |-> halt_req);

    // R7: steered fetch select released by a fetch outside debug mode
    p_fetch_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_sel_q && core_fetch && state_q != ST_DEBUG) |=> !fetch_sel_q);

endmodule

// File: rtl/dbgc_evt_gen.sv
module dbgc_evt_gen
    import dbgc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_sel_e sel,
    input  logic     enter_dbg,
    input  logic     bkpt_hit,
    input  logic     msg_insert,
    output logic     evt_out
);

    logic hit;

    always_comb begin
        unique case (sel)
            EVT_NONE:  hit = 1'b0;
            EVT_ENTRY: hit = enter_dbg;
            EVT_BKPT:  hit = bkpt_hit;
            EVT_MSG:   hit = msg_insert;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_out <= 1'b0;
        end else begin
            evt_out <= hit;
        end
    end

    // R9: message select turns an insertion into a pulse
    p_msg_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EVT_MSG && msg_insert) |=> evt_out);

    // R9: nothing selected means no pulse
    p_none_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EVT_NONE) |=> !evt_out);

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
    import dbgc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              core_sleep,
    input  logic              core_wake_done,
    input  logic              core_retire,
    input  logic              core_debug_ret,
    input  logic              core_fetch,
    input  logic              bkpt_hit,
    input  logic              msg_insert,
    output logic              dbg_mode,
    output logic              wake_req,
    output logic              halt_req,
    output logic              fetch_sel_dir,
    output logic              evt_out,
    output logic              trace_qa
);

    ctrl_t ctrl;
    logic  enter_dbg;

    dbgc_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .enter_dbg  (enter_dbg),
        .fetch_sel  (fetch_sel_dir),
        .core_fetch (core_fetch),
        .ctrl       (ctrl),
        .rdata      (reg_rdata)
    );

    dbgc_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (ctrl.en),
        .req            (ctrl.req),
        .step           (ctrl.step),
        .repl           (ctrl.repl),
        .core_sleep     (core_sleep),
        .core_wake_done (core_wake_done),
        .core_retire    (core_retire),
        .core_debug_ret (core_debug_ret),
        .core_fetch     (core_fetch),
        .bkpt_hit       (bkpt_hit),
        .enter_dbg      (enter_dbg),
        .dbg_mode       (dbg_mode),
        .wake_req       (wake_req),
        .halt_req       (halt_req),
        .fetch_sel      (fetch_sel_dir)
    );

    dbgc_evt_gen u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (ctrl.evt),
        .enter_dbg  (enter_dbg),
        .bkpt_hit   (bkpt_hit),
        .msg_insert (msg_insert),
        .evt_out    (evt_out)
    );

    assign trace_qa = ctrl.qa;

    // R10: trace style output follows the stored bit
    p_trace_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trace_qa == reg_rdata[BIT_QA]);

endmodule

// File: tb/dbg_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_mode_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_sleep = 1'b0;
    logic        core_wake_done = 1'b0;
    logic        core_retire = 1'b0;
    logic        core_debug_ret = 1'b0;
    logic        core_fetch = 1'b0;
    logic        bkpt_hit = 1'b0;
    logic        msg_insert = 1'b0;
    logic        dbg_mode, wake_req, halt_req, fetch_sel_dir, evt_out, trace_qa;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dbg_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_sleep(core_sleep),
        .core_wake_done(core_wake_done), .core_retire(core_retire),
        .core_debug_ret(core_debug_ret), .core_fetch(core_fetch),
        .bkpt_hit(bkpt_hit), .msg_insert(msg_insert), .dbg_mode(dbg_mode),
        .wake_req(wake_req), .halt_req(halt_req), .fetch_sel_dir(fetch_sel_dir),
        .evt_out(evt_out), .trace_qa(trace_qa)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // 0 debug_ret, 1 retire, 2 bkpt, 3 msg, 4 fetch
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: core_debug_ret = 1'b1;
            1: core_retire = 1'b1;
            2: bkpt_hit = 1'b1;
            3: msg_insert = 1'b1;
            default: core_fetch = 1'b1;
        endcase
        @(negedge clk);
        core_debug_ret = 1'b0;
        core_retire = 1'b0;
        bkpt_hit = 1'b0;
        msg_insert = 1'b0;
        core_fetch = 1'b0;
    endtask

    task automatic leave_debug();
        write_word(32'h0);
        pulse(0);
    endtask

    task automatic t_reset();
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 outputs", {26'b0, dbg_mode, wake_req, halt_req, evt_out, fetch_sel_dir, trace_qa}, 32'h0);
    endtask

    task automatic t_reserved();
        write_word(32'hFFFF_FF00);
        check("R11 reserved read zero", reg_rdata, 32'h0);
    endtask

    task automatic t_trace();
        write_word(32'h08);
        check("R10 trace stored", reg_rdata, 32'h08);
        check("R10 trace level", {31'b0, trace_qa}, 32'h1);
        write_word(32'h00);
        check("R10 trace cleared", {31'b0, trace_qa}, 32'h0);
    endtask

    task automatic t_disabled();
        write_word(32'h02);
        check("R2 request dropped without enable", reg_rdata, 32'h0);
        @(negedge clk);
        check("R2 no entry without enable", {31'b0, dbg_mode}, 32'h0);
        pulse(2);
        @(negedge clk);
        check("R2 breakpoint ignored without enable", {31'b0, dbg_mode}, 32'h0);
    endtask

    task automatic t_request();
        write_word(32'h16);
        check("R2 request stored", reg_rdata, 32'h16);
        @(negedge clk);
        check("R2 entry", {31'b0, dbg_mode}, 32'h1);
        check("R4 request self-clear", reg_rdata, 32'h14);
        check("R12 halt pulse", {31'b0, halt_req}, 32'h1);
        check("R9 entry event", {31'b0, evt_out}, 32'h1);
        @(negedge clk);
        check("R12 halt one cycle", {31'b0, halt_req}, 32'h0);
        check("R9 event one cycle", {31'b0, evt_out}, 32'h0);
        leave_debug();
        check("R2 resume", {31'b0, dbg_mode}, 32'h0);
        @(negedge clk);
        check("R4 no re-entry", {31'b0, dbg_mode}, 32'h0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 32'h06;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R4 clear beats write", reg_rdata, 32'h04);
        check("R4 entered", {31'b0, dbg_mode}, 32'h1);
        leave_debug();
        @(negedge clk);
        check("R4 stays out after collision", {31'b0, dbg_mode}, 32'h0);
    endtask

    task automatic t_sleep();
        core_sleep = 1'b1;
        write_word(32'h06);
        @(negedge clk);
        check("R3 wake requested", {30'b0, wake_req, dbg_mode}, 32'h2);
        repeat (3) @(negedge clk);
        check("R3 wake held", {30'b0, wake_req, dbg_mode}, 32'h2);
        check("R3 request pending", reg_rdata, 32'h06);
        core_wake_done = 1'b1;
        core_sleep = 1'b0;
        @(negedge clk);
        core_wake_done = 1'b0;
        check("R3 debug after wake", {30'b0, wake_req, dbg_mode}, 32'h1);
        check("R4 cleared at wake entry", reg_rdata, 32'h04);
        leave_debug();
    endtask

    task automatic t_step();
        write_word(32'h25);
        pulse(2);
        check("R2 breakpoint entry", {31'b0, dbg_mode}, 32'h1);
        check("R9 breakpoint event", {31'b0, evt_out}, 32'h1);
        pulse(0);
        check("R5 step leaves debug", {31'b0, dbg_mode}, 32'h0);
        repeat (3) @(negedge clk);
        check("R5 waits for retire", {31'b0, dbg_mode}, 32'h0);
        pulse(1);
        check("R5 back after one retire", {30'b0, dbg_mode, halt_req}, 32'h3);
        check("R6 step sticky", reg_rdata, 32'h25);
        write_word(32'h24);
        pulse(0);
        pulse(1);
        check("R6 step off resumes run", {31'b0, dbg_mode}, 32'h0);
        write_word(32'h00);
    endtask

    task automatic t_replace();
        write_word(32'h06);
        @(negedge clk);
        write_word(32'h44);
        check("R7 replace stored", reg_rdata, 32'h44);
        pulse(0);
        check("R7 fetch steered", {30'b0, fetch_sel_dir, dbg_mode}, 32'h2);
        @(negedge clk);
        check("R7 steer held", {31'b0, fetch_sel_dir}, 32'h1);
        pulse(4);
        check("R7 steer released", {31'b0, fetch_sel_dir}, 32'h0);
        check("R7 replace auto-clear", reg_rdata, 32'h04);
    endtask

    task automatic t_replace_rst();
        write_word(32'hC4);
        check("R8 set blocked by reset bit", reg_rdata, 32'h04);
        write_word(32'h44);
        write_word(32'h84);
        check("R8 clear blocked by reset bit", reg_rdata, 32'h44);
        write_word(32'h00);
    endtask

    task automatic t_events();
        write_word(32'h30);
        pulse(3);
        check("R9 message event", {31'b0, evt_out}, 32'h1);
        @(negedge clk);
        check("R9 message event one cycle", {31'b0, evt_out}, 32'h0);
        write_word(32'h00);
        pulse(3);
        check("R9 none selected", {31'b0, evt_out}, 32'h0);
        write_word(32'h10);
        pulse(3);
        check("R9 entry select ignores message", {31'b0, evt_out}, 32'h0);
        write_word(32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_trace();
        t_disabled();
        t_request();
        t_collide();
        t_sleep();
        t_step();
        t_replace();
        t_replace_rst();
        t_events();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule